// File: doc/BRIEF.md
# Converter Serial Read and Configure Port

This block is the device-side serial port of a multichannel converter. The host uses a four-wire SPI-style link: it drives chip select, the serial clock and the data input, and it reads the data output. While chip select is low and no result is waiting, the data output shows whether a conversion is still running. Once a result is ready, the port shifts out a 32-bit word, most significant bit first. During the same transfer it takes a 13-bit configuration word, which selects speed/resolution and channel, from the data input.

The host can end a transfer early by raising chip select. If that happens after enough clock edges, the read is abandoned and a fresh conversion starts at once. The new configuration survives only if the rise comes late enough in the transfer. A cycle-count timer stands in for the converter. It builds each result word from a running conversion number and the configuration in effect. All three host inputs are brought into the system clock through two-flop synchronizers, and their edges are detected on the synchronized copies.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, a conversion is running (`conv_busy` high), `cfg_active` equals `CFG_RESET` (zero by default), and with chip select high `sdo_oe` and `sdo` are both low.
- R2: While chip select is low and no read is in progress, `sdo` shows the conversion status: 1 while converting, 0 once a result is ready.
- R3: The data word is 32 bits, sent MSB first. Bit 31 is 0, meaning a valid result. Bit 30 is 0. Bit 29 is the sign, equal to bit 0 of the conversion number. Bits 28:13 hold the 16-bit conversion number, which is 0 for the first result after reset. Bits 12:0 hold the configuration in effect. After k synchronized falling SCK edges, `sdo` shows bit 31-k.
- R4: SDI is sampled on rising SCK edges. Only the first 13 rising edges of a read are used, and the first bit received becomes configuration bit 12.
- R5: On the 32nd falling SCK edge the received configuration is stored and a new conversion starts.
- R6: If chip select rises after the 5th falling edge has been seen, and before the 32nd, the read ends and a new conversion starts immediately.
- R7: A chip-select rise with fewer than 14 falling edges seen leaves `cfg_active` unchanged. A rise with 14 or more stores the received configuration.
- R8: A chip-select rise with fewer than 5 falling edges seen starts no conversion and keeps the result. The next chip-select fall presents the same word again from bit 31.
- R9: `sdo_oe` is high exactly while the synchronized chip select is low, and `sdo` is 0 whenever `sdo_oe` is low.
- R10: SCK and SDI activity while chip select is high, or while only status is being shown, does not change `cfg_active` or the conversion state.
- R11: A conversion lasts `CONV_CYCLES` system clocks after its start is registered. Each completed conversion increments the conversion number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| sck | input | 1 | Host serial clock, asynchronous |
| sdi | input | 1 | Serial configuration data from host |
| sdo | output | 1 | Serial status/data to host |
| sdo_oe | output | 1 | Output enable for sdo (high-impedance when low) |
| conv_busy | output | 1 | Stand-in conversion in progress |
| cfg_active | output | 13 | Configuration in effect for conversions |

## Verification
The assertions assume that a chip-select rise and a falling SCK edge never reach the synchronized domain in the same system clock. They also assume that each SCK and chip-select level is held for at least three system clocks, so no edge is lost in the synchronizers. The stimulus changes only one host pin at a time and holds every level for six system clocks. It places chip-select rises on exact falling-edge counts (4, 5, 13, 14, 20, 32) to hit the abort and commit thresholds.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int CONV_CYCLES = 300,
  parameter int WORD_W = 32,
  parameter int CFG_W = 13,
  parameter int ABORT_MIN = 5,
  parameter int COMMIT_MIN = 14,
  parameter logic [CFG_W-1:0] CFG_RESET = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             conv_busy,
  output logic [CFG_W-1:0] cfg_active
);
  localparam int SEQ_W  = WORD_W - 3 - CFG_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int RCNT_W = $clog2(CFG_W + 1);
  localparam int TMR_W  = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0]  LAST_FALL = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0]  ABORT_AT  = CNT_W'(ABORT_MIN);
  localparam logic [CNT_W-1:0]  COMMIT_AT = CNT_W'(COMMIT_MIN);
  localparam logic [RCNT_W-1:0] CFG_FULL  = RCNT_W'(CFG_W);
  localparam logic [TMR_W-1:0]  TMR_LOAD  = TMR_W'(CONV_CYCLES - 1);

  logic [2:0] cs_p, sck_p;
  logic [1:0] sdi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p  <= 3'b111;
      sck_p <= 3'b000;
      sdi_p <= 2'b00;
    end else begin
      cs_p  <= {cs_p[1:0], cs_n};
      sck_p <= {sck_p[1:0], sck};
      sdi_p <= {sdi_p[0], sdi};
    end
  end

  logic cs_low, cs_rise, sck_rise, sck_fall, sdi_s;
  assign cs_low   = ~cs_p[1];
  assign cs_rise  = cs_p[1] & ~cs_p[2];
  assign sck_rise = sck_p[1] & ~sck_p[2];
  assign sck_fall = ~sck_p[1] & sck_p[2];
  assign sdi_s    = sdi_p[1];

  logic              busy, reading;
  logic [TMR_W-1:0]  timer;
  logic [CNT_W-1:0]  fall_cnt;
  logic [RCNT_W-1:0] rise_cnt;
  logic [CFG_W-1:0]  shreg, cfg_q;
  logic [SEQ_W-1:0]  seq;
  logic [WORD_W-1:0] word;

  logic end_full, end_abort, end_early, conv_start, commit;
  assign end_full   = reading & sck_fall & (fall_cnt == LAST_FALL);
  assign end_abort  = reading & cs_rise & (fall_cnt >= ABORT_AT);
  assign end_early  = reading & cs_rise & (fall_cnt < ABORT_AT);
  assign conv_start = end_full | end_abort;
  assign commit     = end_full |
                      (end_abort & (fall_cnt >= COMMIT_AT) & (rise_cnt == CFG_FULL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b1;
      timer <= TMR_LOAD;
      seq   <= '0;
      word  <= '0;
      cfg_q <= CFG_RESET;
    end else if (conv_start) begin
      busy  <= 1'b1;
      timer <= TMR_LOAD;
      if (commit) cfg_q <= shreg;
    end else if (busy) begin
      if (timer == '0) begin
        busy <= 1'b0;
        word <= {2'b00, seq[0], seq, cfg_q};
        seq  <= seq + 1'b1;
      end else begin
        timer <= timer - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reading  <= 1'b0;
      fall_cnt <= '0;
      rise_cnt <= '0;
      shreg    <= '0;
    end else if (reading) begin
      if (conv_start | end_early) begin
        reading <= 1'b0;
      end else begin
        if (sck_fall) fall_cnt <= fall_cnt + 1'b1;
        if (sck_rise && rise_cnt != CFG_FULL) begin
          shreg    <= {shreg[CFG_W-2:0], sdi_s};
          rise_cnt <= rise_cnt + 1'b1;
        end
      end
    end else if (cs_low && !busy) begin
      reading  <= 1'b1;
      fall_cnt <= '0;
      rise_cnt <= '0;
    end
  end

  logic [IDX_W-1:0] bit_idx;
  assign bit_idx    = IDX_W'(LAST_FALL - fall_cnt);
  assign sdo_oe     = cs_low;
  assign sdo        = cs_low & (reading ? word[bit_idx] : busy);
  assign conv_busy  = busy;
  assign cfg_active = cfg_q;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int WORD_W = 32,
  parameter int CFG_W = 13,
  parameter int ABORT_MIN = 5,
  parameter int COMMIT_MIN = 14,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reading,
  input logic             busy,
  input logic             cs_rise,
  input logic             sck_fall,
  input logic [CNT_W-1:0] fall_cnt,
  input logic [CFG_W-1:0] cfg_active,
  input logic             sdo,
  input logic             sdo_oe
);
  assert_full_read_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && sck_fall && fall_cnt == CNT_W'(WORD_W - 1)) |=> (busy && !reading));

  assert_abort_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && cs_rise && fall_cnt >= CNT_W'(ABORT_MIN)) |=> busy);

  assert_early_rise_keeps_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && cs_rise && fall_cnt < CNT_W'(ABORT_MIN)) |=> (!busy && !reading));

  assert_short_read_discards_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && cs_rise && fall_cnt < CNT_W'(COMMIT_MIN)) |=> $stable(cfg_active));

  assert_cfg_only_from_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reading |=> $stable(cfg_active));

  assert_no_read_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !reading);

  assert_quiet_when_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
endmodule

bind adc_serial_port adc_serial_port_chk #(
  .WORD_W(WORD_W), .CFG_W(CFG_W), .ABORT_MIN(ABORT_MIN),
  .COMMIT_MIN(COMMIT_MIN), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reading(reading), .busy(busy),
  .cs_rise(cs_rise), .sck_fall(sck_fall), .fall_cnt(fall_cnt),
  .cfg_active(cfg_active), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/adc_serial_port_tb_top.sv
module adc_serial_port_tb_top;
  localparam int CONV = 300;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, conv_busy;
  logic [12:0] cfg_active;

  always #4 clk = ~clk;

  adc_serial_port #(.CONV_CYCLES(CONV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .conv_busy(conv_busy), .cfg_active(cfg_active)
  );

  int cyc = 0, last_change = 0, n_checks = 0, n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit m_on = 0, m_cs = 1, m_busy = 1, m_reading = 0;
  int m_fall = 0, m_rise = 0, m_end = 1 << 30;
  logic [12:0] m_shift = '0, m_cfg = '0;
  logic [15:0] m_seq = '0;
  logic [31:0] m_word = '0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (m_on) begin
    if (m_busy && cyc >= m_end) begin
      m_busy = 0;
      m_word = {2'b00, m_seq[0], m_seq, m_cfg};
      m_seq++;
    end
    if (!m_busy && !m_reading && !m_cs) begin
      m_reading = 1; m_fall = 0; m_rise = 0;
    end
    if ((cyc - last_change >= 4) && (cyc < m_end - 3 || cyc > m_end + 3)) begin
      check(sdo_oe == !m_cs, "R9 output enable", sdo_oe, !m_cs);
      if (m_cs) check(sdo == 1'b0, "R9 idle data", sdo, 0);
      else if (m_reading) check(sdo == m_word[31 - m_fall], "R3 data bit", sdo, m_word[31 - m_fall]);
      else check(sdo == m_busy, "R2 status bit", sdo, m_busy);
      check(conv_busy == m_busy, "R11 busy", conv_busy, m_busy);
      check(cfg_active == m_cfg, "R7 config", cfg_active, m_cfg);
    end
  end

  task automatic step();
    repeat (H) @(posedge clk);
    #1;
  endtask

  task automatic m_start();
    m_busy = 1; m_reading = 0; m_end = cyc + 3 + CONV;
  endtask

  task automatic cs_down();
    step(); cs_n = 1'b0; m_cs = 0; last_change = cyc;
  endtask

  task automatic cs_up();
    step(); cs_n = 1'b1; m_cs = 1; last_change = cyc;
    if (m_reading) begin
      if (m_fall >= 5) begin
        if (m_fall >= 14) m_cfg = m_shift;
        m_start();
      end
      m_reading = 0;
    end
  endtask

  task automatic clk_bit(input bit d, output bit seen);
    step(); sdi = d; last_change = cyc;
    @(negedge clk) seen = sdo;
    step(); sck = 1'b1; last_change = cyc;
    if (m_reading && !m_cs && m_rise < 13) begin
      m_shift = {m_shift[11:0], d}; m_rise++;
    end
    step(); sck = 1'b0; last_change = cyc;
    if (m_reading && !m_cs) begin
      m_fall++;
      if (m_fall == 32) begin m_cfg = m_shift; m_start(); end
    end
  endtask

  task automatic do_read(input logic [12:0] c, input int n, output logic [31:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      bit d;
      bit s;
      d = (i < 13) ? c[12 - i] : bit'(i % 2);
      clk_bit(d, s);
      got[31 - i] = s;
    end
  endtask

  task automatic wait_ready();
    int guard;
    guard = 0;
    repeat (8) @(negedge clk);
    while (conv_busy !== 1'b0 && guard < 2000) begin
      @(negedge clk); guard++;
    end
    check(guard < 2000, "R11 conversion completes", guard, 2000);
    repeat (8) @(posedge clk);
  endtask

  initial begin
    logic [31:0] got, exp_w;
    bit s;
    int c0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    m_end = cyc + CONV; m_on = 1; last_change = cyc;
    @(negedge clk);
    check(conv_busy == 1'b1, "R1 busy after reset", conv_busy, 1);
    check(sdo_oe == 1'b0, "R1 output released", sdo_oe, 0);
    check(sdo == 1'b0, "R1 data low", sdo, 0);
    check(cfg_active == 13'h0, "R1 reset config", cfg_active, 0);

    // R2 / R10: status and ignored clocks while converting
    cs_down();
    for (int i = 0; i < 3; i++) begin
      clk_bit(1'b1, s);
      check(s == 1'b1, "R2 status high while converting", s, 1);
    end
    wait_ready();
    // R3 / R4 / R5: full read of the first word
    exp_w = m_word;
    do_read(13'h1A5B, 32, got);
    check(got == 32'h0, "R3 first word", got, 32'h0);
    check(got == exp_w, "R3 word matches model", got, exp_w);
    step();
    check(cfg_active == 13'h1A5B, "R4 R5 config stored after full read", cfg_active, 13'h1A5B);
    check(conv_busy == 1'b1, "R5 conversion restarted", conv_busy, 1);
    cs_up();

    // R7 boundary: 13 falls discards, R6 abort restarts
    wait_ready();
    cs_down();
    exp_w = m_word;
    do_read(13'h0F0F, 13, got);
    check(got[31:19] == exp_w[31:19], "R3 leading bits", got[31:19], exp_w[31:19]);
    check(exp_w[29] == 1'b1, "R3 sign of second word", exp_w[29], 1);
    cs_up(); step();
    check(conv_busy == 1'b1, "R6 abort at 13 restarts", conv_busy, 1);
    check(cfg_active == 13'h1A5B, "R7 13 edges discard", cfg_active, 13'h1A5B);

    // R7 boundary: 14 falls commits
    wait_ready();
    cs_down();
    do_read(13'h0F0F, 14, got);
    cs_up(); step();
    check(cfg_active == 13'h0F0F, "R7 14 edges commit", cfg_active, 13'h0F0F);
    check(conv_busy == 1'b1, "R6 abort at 14 restarts", conv_busy, 1);

    // R8: early rise keeps result, word re-presented
    wait_ready();
    cs_down();
    do_read(13'h1111, 4, got);
    cs_up(); step();
    check(conv_busy == 1'b0, "R8 no new conversion", conv_busy, 0);
    check(cfg_active == 13'h0F0F, "R8 config kept", cfg_active, 13'h0F0F);
    exp_w = m_word;
    cs_down();
    do_read(13'h0AAA, 32, got);
    check(got == exp_w, "R8 word re-presented from bit 31", got, exp_w);
    check(got[12:0] == 13'h0F0F, "R3 config field", got[12:0], 13'h0F0F);
    cs_up();

    // R6 boundary: abort at exactly 5
    wait_ready();
    cs_down();
    do_read(13'h1555, 5, got);
    cs_up(); step();
    check(conv_busy == 1'b1, "R6 abort at 5 restarts", conv_busy, 1);
    check(cfg_active == 13'h0AAA, "R7 5 edges discard", cfg_active, 13'h0AAA);

    // R10: clocks with chip select high are ignored
    wait_ready();
    for (int i = 0; i < 16; i++) clk_bit(1'b1, s);
    step();
    check(conv_busy == 1'b0, "R10 no conversion from idle clocks", conv_busy, 0);
    check(cfg_active == 13'h0AAA, "R10 config untouched", cfg_active, 13'h0AAA);
    check(sdo_oe == 1'b0, "R10 output stays released", sdo_oe, 0);
    cs_down();
    do_read(13'h1C3C, 20, got);
    cs_up();
    c0 = cyc;
    step();
    check(cfg_active == 13'h1C3C, "R7 20 edges commit", cfg_active, 13'h1C3C);
    while (conv_busy !== 1'b0 && cyc - c0 < 2000) @(negedge clk);
    check((cyc - c0 >= CONV + 2) && (cyc - c0 <= CONV + 4), "R11 conversion length",
          cyc - c0, CONV + 3);

    repeat (20) @(posedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  always @(posedge clk) if (cyc > 150000) begin
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected below 150000", cyc);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule